// File: doc/BRIEF.md
# Segmented MMU Translation Unit

This block turns a 32-bit virtual address into a physical address by walking two tables that it keeps in on-chip register arrays. The first is a segment map. It is indexed by the current context number joined with the segment field of the address, and it yields a page-group number. The second is a page table, indexed by that group number joined with the page field of the address. It yields a 32-bit page entry that carries a valid flag, permissions, a cacheability flag, the used and modified flags and the page frame number.

A requester presents one access at a time: the address, a write flag, a user-mode flag and the context. The block answers with a one-cycle response. That response carries either the physical address and the non-cacheable flag, or a fault with a cause code. On every successful access the block rewrites the page entry it hit, so that the entry records the use and, for writes, the modification.

Software fills and inspects both tables through a small configuration port. The port is locked against writes while a walk is in progress. The default parameters implement a reduced table size. The full-size arrangement, with 12 segment bits and 7 group bits, is reached by changing parameters.

Top module: `mmu_xlate`

## Requirements
- R1: After reset every segment-map and page-table entry reads back as zero, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An access whose address bits 31:29 are neither 000 nor 111 faults with cause 1 and touches no table entry. The patterns 000 and 111 both proceed to the table lookup.
- R3: The segment-map index is {context, va[18+VSEG_W-1:18]}, where VSEG_W defaults to 5. The page-table index is {group, va[17:12]}, where the group is the GRP_W-bit segment-map entry.
- R4: The page-entry bits are assigned as follows. Bit 31 is valid, bit 30 is write-allowed, bit 29 is supervisor-only, bit 28 is non-cacheable, bit 25 is used and bit 24 is modified. Bits PFN_W-1:0 hold the frame number, with PFN_W defaulting to 16.
- R5: An access to an entry whose valid bit is 0 faults with cause 2.
- R6: A write to an entry without write permission faults with cause 3. A user-mode access to a supervisor-only entry faults with cause 4. When several conditions apply, the lowest cause number wins, in the order 1, 2, 3, 4.
- R7: A successful access sets the used bit in the stored entry, and a successful write also sets the modified bit. All other entry bits keep their values.
- R8: A faulting access leaves the page entry unchanged and returns a physical address of 0 with non-cacheable 0. A successful response has cause 0.
- R9: On success the physical address is {frame number, va[11:0]}, and `rsp_nc` equals entry bit 28.
- R10: `rsp_valid` is a one-cycle pulse. Counting the edge that accepts the request as edge 0, the response is visible after edge 1 for a hole fault, after edge 3 for any other fault, and after edge 4 on success.
- R11: A configuration write in an idle cycle updates the selected table (`cfg_sel` 0 = segment map, 1 = page table). A configuration read returns the selected entry on `cfg_rdata` after the next edge, with segment entries zero-extended.
- R12: Configuration writes presented while `req_ready` is 0 are ignored.
- R13: Requests presented while `req_ready` is 0 are ignored and produce no response and no table update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctx | input | CTX_W | Current context number, sampled when a request is accepted |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | High while idle; a request is taken only then |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 3 | 0 none, 1 hole, 2 invalid, 3 write-protect, 4 privilege |
| rsp_pa | output | PFN_W+12 | Physical address |
| rsp_nc | output | 1 | Non-cacheable access |
| cfg_en | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_sel | input | 1 | 0 = segment map, 1 = page table |
| cfg_addr | input | CFG_AW | Entry index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |

## Verification
Several properties are checked on every response. The response strobe lasts one cycle and the block returns to idle after it. A hole address always yields cause 1. A fault never carries an address or the non-cacheable flag. A success returns the untranslated low 12 bits. Once a request is accepted, the block stops accepting new ones. Other behaviours need the bench's scenarios, because they depend on table contents: the cause priority across permission combinations, the exact frame number, the used and modified write-back seen by reading the table back, and that blocked configuration writes and stray requests leave the stored entries alone.

// File: rtl/mmu_xlate_pkg.sv
// Shared constants and types for the segmented translation unit.
// Assumes a 4 KiB page (12 offset bits) and a 6-bit page field.
package mmu_xlate_pkg;
    localparam int PG_SHIFT = 12;
    localparam int VPG_W    = 6;
    localparam int SEG_LSB  = 18;

    localparam int PTE_V  = 31;
    localparam int PTE_W  = 30;
    localparam int PTE_S  = 29;
    localparam int PTE_NC = 28;
    localparam int PTE_U  = 25;
    localparam int PTE_M  = 24;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_HOLE    = 3'd1,
        CAUSE_INVALID = 3'd2,
        CAUSE_WPROT   = 3'd3,
        CAUSE_PRIV    = 3'd4
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_SEG, ST_PAGE, ST_WB, ST_DONE
    } walk_st_e;
endpackage

// File: rtl/mmu_regfile.sv
// Register-array table with one write port and two combinational read ports.
// Assumes write conflicts are resolved by the caller; clears to zero on reset.
module mmu_regfile #(
    parameter int AW = 8,
    parameter int DW = 4,
    localparam int DEPTH = 2 ** AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise single-entry write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/mmu_walk_fsm.sv
// Table-walk sequencer: hole check, segment read, page read, permission
// checks, used/modified write-back and a one-cycle response.
// Assumes table reads are combinational and that it owns the page-table
// write port during ST_WB.
module mmu_walk_fsm
    import mmu_xlate_pkg::*;
#(
    parameter int CTX_W  = 3,
    parameter int VSEG_W = 5,
    parameter int GRP_W  = 4,
    parameter int PFN_W  = 16,
    localparam int SEG_AW = CTX_W + VSEG_W,
    localparam int PG_AW  = GRP_W + VPG_W,
    localparam int PA_W   = PFN_W + PG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTX_W-1:0]  ctx,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_va,
    input  logic              req_write,
    input  logic              req_user,
    output logic [SEG_AW-1:0] seg_raddr,
    input  logic [GRP_W-1:0]  seg_rdata,
    output logic [PG_AW-1:0]  pte_addr,
    input  logic [31:0]       pte_rdata,
    output logic              wb_en,
    output logic [31:0]       wb_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [2:0]        rsp_cause,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_nc
);
    walk_st_e           st;
    logic [31:0]        va_q;
    logic               wr_q, usr_q, nc_q;
    logic [CTX_W-1:0]   ctx_q;
    logic [GRP_W-1:0]   grp_q;
    logic [31:0]        pte_q;
    cause_e             cause_q, page_cause;
    logic [PA_W-1:0]    pa_q;
    logic               hole;
    logic               unused_va;

    assign hole      = !((va_q[31:29] == 3'b000) || (va_q[31:29] == 3'b111));
    assign seg_raddr = {ctx_q, va_q[SEG_LSB +: VSEG_W]};
    assign pte_addr  = {grp_q, va_q[PG_SHIFT +: VPG_W]};
    assign unused_va = ^va_q;

    // Permission evaluation of the entry being read, in priority order.
    always_comb begin
        page_cause = CAUSE_NONE;
        if (!pte_rdata[PTE_V])                   page_cause = CAUSE_INVALID;
        else if (wr_q && !pte_rdata[PTE_W])      page_cause = CAUSE_WPROT;
        else if (usr_q && pte_rdata[PTE_S])      page_cause = CAUSE_PRIV;
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            ctx_q   <= '0;
            grp_q   <= '0;
            pte_q   <= '0;
            cause_q <= CAUSE_NONE;
            pa_q    <= '0;
            nc_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_va;
                    wr_q    <= req_write;
                    usr_q   <= req_user;
                    ctx_q   <= ctx;
                    cause_q <= CAUSE_NONE;
                    pa_q    <= '0;
                    nc_q    <= 1'b0;
                    st      <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (hole) begin
                        cause_q <= CAUSE_HOLE;
                        st      <= ST_DONE;
                    end else begin
                        st <= ST_SEG;
                    end
                end
                ST_SEG: begin
                    grp_q <= seg_rdata;
                    st    <= ST_PAGE;
                end
                ST_PAGE: begin
                    pte_q   <= pte_rdata;
                    cause_q <= page_cause;
                    if (page_cause != CAUSE_NONE) begin
                        st <= ST_DONE;
                    end else begin
                        pa_q <= {pte_rdata[PFN_W-1:0], va_q[PG_SHIFT-1:0]};
                        nc_q <= pte_rdata[PTE_NC];
                        st   <= ST_WB;
                    end
                end
                ST_WB:   st <= ST_DONE;
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign wb_en     = (st == ST_WB);
    assign wb_data   = pte_q | (32'(1) << PTE_U) | (wr_q ? (32'(1) << PTE_M) : 32'd0);
    assign rsp_valid = (st == ST_DONE);
    assign rsp_fault = (cause_q != CAUSE_NONE);
    assign rsp_cause = cause_q;
    assign rsp_pa    = pa_q;
    assign rsp_nc    = nc_q;
endmodule

// File: rtl/mmu_xlate.sv
// Top of the segmented translation unit: two table arrays, the walk
// sequencer and the configuration port. Configuration writes are honoured
// only while the sequencer is idle, so they never collide with write-back.
module mmu_xlate
    import mmu_xlate_pkg::*;
#(
    parameter int CTX_W  = 3,
    parameter int VSEG_W = 5,
    parameter int GRP_W  = 4,
    parameter int PFN_W  = 16,
    localparam int SEG_AW = CTX_W + VSEG_W,
    localparam int PG_AW  = GRP_W + VPG_W,
    localparam int CFG_AW = (SEG_AW > PG_AW) ? SEG_AW : PG_AW,
    localparam int PA_W   = PFN_W + PG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTX_W-1:0]  ctx,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_va,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [2:0]        rsp_cause,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_nc,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata
);
    logic [SEG_AW-1:0] seg_raddr;
    logic [GRP_W-1:0]  seg_rd_a, seg_rd_b;
    logic [PG_AW-1:0]  pte_addr;
    logic [31:0]       pt_rd_a, pt_rd_b, wb_data;
    logic              wb_en, cfg_wr_ok;
    logic              pt_we;
    logic [PG_AW-1:0]  pt_waddr;
    logic [31:0]       pt_wdata;
    logic              unused_cfg;

    assign cfg_wr_ok  = cfg_en && cfg_we && req_ready;
    assign pt_we      = wb_en || (cfg_wr_ok && cfg_sel);
    assign pt_waddr   = wb_en ? pte_addr : cfg_addr[PG_AW-1:0];
    assign pt_wdata   = wb_en ? wb_data  : cfg_wdata;
    assign unused_cfg = ^{cfg_addr, cfg_wdata};

    mmu_regfile #(.AW(SEG_AW), .DW(GRP_W)) u_segmap (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_wr_ok && !cfg_sel),
        .waddr(cfg_addr[SEG_AW-1:0]), .wdata(cfg_wdata[GRP_W-1:0]),
        .raddr_a(seg_raddr), .rdata_a(seg_rd_a),
        .raddr_b(cfg_addr[SEG_AW-1:0]), .rdata_b(seg_rd_b)
    );

    mmu_regfile #(.AW(PG_AW), .DW(32)) u_pagetab (
        .clk(clk), .rst_n(rst_n),
        .we(pt_we), .waddr(pt_waddr), .wdata(pt_wdata),
        .raddr_a(pte_addr), .rdata_a(pt_rd_a),
        .raddr_b(cfg_addr[PG_AW-1:0]), .rdata_b(pt_rd_b)
    );

    mmu_walk_fsm #(.CTX_W(CTX_W), .VSEG_W(VSEG_W), .GRP_W(GRP_W), .PFN_W(PFN_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .ctx(ctx),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_write(req_write), .req_user(req_user),
        .seg_raddr(seg_raddr), .seg_rdata(seg_rd_a),
        .pte_addr(pte_addr), .pte_rdata(pt_rd_a),
        .wb_en(wb_en), .wb_data(wb_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_pa(rsp_pa), .rsp_nc(rsp_nc)
    );

    // Registered configuration read of the selected table.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cfg_rdata <= '0;
        else if (cfg_en && !cfg_we)  cfg_rdata <= cfg_sel ? pt_rd_b : 32'(seg_rd_b);
    end
endmodule

// File: rtl/mmu_xlate_chk.sv
// Protocol and result checker for mmu_xlate, attached by bind.
// Keeps its own copy of the accepted address to judge each response.
module mmu_xlate_chk #(
    parameter int PA_W = 28
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [31:0]     req_va,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [2:0]      rsp_cause,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_nc
);
    logic [31:0] seen_va;
    logic        seen_hole;
    logic        unused_va;

    // Capture the address of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      seen_va <= '0;
        else if (req_valid && req_ready) seen_va <= req_va;
    end

    assign seen_hole = !((seen_va[31:29] == 3'b000) || (seen_va[31:29] == 3'b111));
    assign unused_va = ^seen_va;

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_RSP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready); // R10
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R13
    AST_HOLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && seen_hole) |-> (rsp_fault && rsp_cause == 3'd1)); // R2
    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault ? (rsp_cause >= 3'd1 && rsp_cause <= 3'd4) : (rsp_cause == 3'd0))); // R6
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && !rsp_nc)); // R8
    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[11:0] == seen_va[11:0])); // R9
endmodule

bind mmu_xlate mmu_xlate_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_pa(rsp_pa), .rsp_nc(rsp_nc)
);

// File: tb/tb_mmu_xlate.sv
module tb_mmu_xlate;
    localparam int CTX_W = 3, VSEG_W = 5, GRP_W = 4, PFN_W = 16;
    localparam int SEG_AW = CTX_W + VSEG_W, PG_AW = GRP_W + 6;
    localparam int CFG_AW = (SEG_AW > PG_AW) ? SEG_AW : PG_AW;
    localparam int PA_W = PFN_W + 12;
    localparam logic [31:0] BV = 32'h8000_0000, BW = 32'h4000_0000,
                            BS = 32'h2000_0000, BNC = 32'h1000_0000,
                            BU = 32'h0200_0000, BM = 32'h0100_0000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [CTX_W-1:0]  ctx = '0;
    logic              req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0]       req_va = '0;
    logic              req_ready, rsp_valid, rsp_fault, rsp_nc;
    logic [2:0]        rsp_cause;
    logic [PA_W-1:0]   rsp_pa;
    logic              cfg_en = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0, cfg_rdata;

    mmu_xlate dut (
        .clk(clk), .rst_n(rst_n), .ctx(ctx),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_pa(rsp_pa), .rsp_nc(rsp_nc),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    int n_chk = 0, n_fail = 0;
    logic [GRP_W-1:0] seg_m [2**SEG_AW];
    logic [31:0]      pg_m  [2**PG_AW];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input bit sel, input int addr, input logic [31:0] d);
        @(negedge clk);
        cfg_en = 1; cfg_we = 1; cfg_sel = sel; cfg_addr = CFG_AW'(addr); cfg_wdata = d;
        @(negedge clk);
        cfg_en = 0; cfg_we = 0;
        if (sel) pg_m[addr] = d;
        else     seg_m[addr] = d[GRP_W-1:0];
    endtask

    task automatic cfg_read(input bit sel, input int addr, output logic [31:0] d);
        @(negedge clk);
        cfg_en = 1; cfg_we = 0; cfg_sel = sel; cfg_addr = CFG_AW'(addr);
        @(negedge clk);
        cfg_en = 0;
        d = cfg_rdata;
    endtask

    // Expected outcome computed from the requirements and the table model.
    function automatic void predict(input logic [31:0] va, input bit w, input bit u,
                                    input logic [CTX_W-1:0] c, output logic [2:0] cause,
                                    output logic [PA_W-1:0] pa, output bit nc,
                                    output int lat, output int pidx);
        logic [SEG_AW-1:0] sidx;
        logic [31:0] pte;
        pa = '0; nc = 0; pidx = 0;
        if (!(va[31:29] == 3'b000 || va[31:29] == 3'b111)) begin
            cause = 3'd1; lat = 1; return;
        end
        sidx = {c, va[18 +: VSEG_W]};
        pidx = int'({seg_m[sidx], va[17:12]});
        pte  = pg_m[pidx];
        if (!pte[31])              cause = 3'd2;
        else if (w && !pte[30])    cause = 3'd3;
        else if (u && pte[29])     cause = 3'd4;
        else                       cause = 3'd0;
        if (cause != 0) lat = 3;
        else begin
            lat = 4;
            pa  = {pte[PFN_W-1:0], va[11:0]};
            nc  = pte[28];
        end
    endfunction

    // One translation with full result and table checks. With inject set, a
    // configuration write to slot inj_slot and a stray request are driven
    // while the walk is busy.
    task automatic translate(input logic [31:0] va, input bit w, input bit u,
                             input logic [CTX_W-1:0] c, input bit inject,
                             input int inj_slot, input logic [31:0] stray_va);
        logic [2:0] e_cause; logic [PA_W-1:0] e_pa; bit e_nc; int e_lat, pidx, lat;
        logic [31:0] rb;
        string tag;
        predict(va, w, u, c, e_cause, e_pa, e_nc, e_lat, pidx);
        tag = (e_cause == 1) ? "R2" : (e_cause == 2) ? "R5" : (e_cause != 0) ? "R6" : "R9";
        @(negedge clk);
        ctx = c; req_va = va; req_write = w; req_user = u; req_valid = 1;
        chk("R10 ready before request", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 0;
        lat = 0;
        while (!rsp_valid && lat < 40) begin
            if (inject && lat == 0) begin
                req_valid = 1; req_va = stray_va; req_write = 1; req_user = 0;
                cfg_en = 1; cfg_we = 1; cfg_sel = 1;
                cfg_addr = CFG_AW'(inj_slot); cfg_wdata = 32'hDEAD_BEEF;
            end
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (inject && lat == 1) begin
                req_valid = 0; cfg_en = 0; cfg_we = 0;
            end
        end
        chk({tag, " fault"}, 32'(rsp_fault), 32'(e_cause != 0));
        chk({tag, " cause"}, 32'(rsp_cause), 32'(e_cause));
        chk({tag, " pa"}, 32'(rsp_pa), 32'(e_pa));
        chk({tag, " nc"}, 32'(rsp_nc), 32'(e_nc));
        chk("R10 latency", 32'(lat), 32'(e_lat));
        if (e_cause == 0) pg_m[pidx] = pg_m[pidx] | BU | (w ? BM : 32'd0);
        if (e_cause != 1) begin
            cfg_read(1, pidx, rb);
            chk((e_cause == 0) ? "R7 entry write-back" : "R8 entry unchanged", rb, pg_m[pidx]);
        end
        if (inject) begin
            repeat (4) begin
                @(negedge clk);
                chk("R13 no extra response", 32'(rsp_valid), 32'd0);
            end
            cfg_read(1, inj_slot, rb);
            chk("R12 R13 busy slot untouched", rb, pg_m[inj_slot]);
        end
    endtask

    function automatic logic [31:0] mkva(input logic [2:0] top, input int vseg,
                                         input int vpg, input int off);
        return {top, 6'd0, 5'(vseg), 6'(vpg), 12'(off)};
    endfunction

    initial begin
        logic [31:0] rb;
        foreach (seg_m[i]) seg_m[i] = '0;
        foreach (pg_m[i])  pg_m[i]  = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 no response", 32'(rsp_valid), 32'd0);
        cfg_read(0, 8'h43, rb); chk("R1 segment entry zero", rb, 32'd0);
        cfg_read(1, 581, rb);   chk("R1 page entry zero", rb, 32'd0);

        // R11 configuration write and read-back; R3 index layout
        cfg_write(0, {3'd2, 5'd3}, 32'hFFFF_FFF9);
        cfg_read(0, {3'd2, 5'd3}, rb); chk("R11 segment zero-extended", rb, 32'h9);
        cfg_write(1, 9*64 + 5, BV | BW | BNC | 32'h0000_BEEF);
        cfg_read(1, 9*64 + 5, rb); chk("R11 page entry", rb, BV | BW | BNC | 32'h0000_BEEF);

        // R3 R4 R9 read then write through the same slot; R7 used/modified
        translate(mkva(3'b000, 3, 5, 12'hABC), 0, 1, 3'd2, 0, 0, 0);
        translate(mkva(3'b111, 3, 5, 12'h123), 1, 0, 3'd2, 0, 0, 0);
        // R3: another context with the same address misses into an empty entry
        translate(mkva(3'b000, 3, 5, 12'h0), 0, 0, 3'd5, 0, 0, 0);

        // R2 hole patterns
        translate(mkva(3'b001, 3, 5, 1), 0, 0, 3'd2, 0, 0, 0);
        translate(mkva(3'b010, 3, 5, 2), 1, 1, 3'd2, 0, 0, 0);
        translate(mkva(3'b100, 3, 5, 3), 0, 0, 3'd2, 0, 0, 0);
        translate(mkva(3'b110, 3, 5, 4), 0, 1, 3'd2, 0, 0, 0);

        // R5 R6 cause priority, group 9 pages 10..13
        cfg_write(1, 9*64 + 10, BS | 32'h1111);           // invalid, ro, sup
        cfg_write(1, 9*64 + 11, BV | BS | 32'h2222);      // ro, sup
        cfg_write(1, 9*64 + 12, BV | BW | BS | 32'h3333); // sup only
        cfg_write(1, 9*64 + 13, BV | BS | BM | 32'h4444); // sup read
        translate(mkva(3'b000, 3, 10, 7), 1, 1, 3'd2, 0, 0, 0);
        translate(mkva(3'b000, 3, 11, 7), 1, 1, 3'd2, 0, 0, 0);
        translate(mkva(3'b000, 3, 12, 7), 1, 1, 3'd2, 0, 0, 0);
        translate(mkva(3'b000, 3, 13, 7), 0, 0, 3'd2, 0, 0, 0);
        translate(mkva(3'b000, 3, 12, 8), 1, 0, 3'd2, 0, 0, 0);

        // R12 R13 writes and requests while busy, for success and hole walks
        cfg_write(1, 9*64 + 20, BV | BW | 32'h5555);
        translate(mkva(3'b000, 3, 5, 9), 0, 0, 3'd2, 1, 9*64 + 20, mkva(3'b000, 3, 20, 0));
        translate(mkva(3'b011, 3, 5, 9), 0, 0, 3'd2, 1, 9*64 + 20, mkva(3'b000, 3, 20, 0));

        // Random tables and accesses
        for (int i = 0; i < 2**SEG_AW; i++) cfg_write(0, i, $urandom);
        for (int i = 0; i < 2**PG_AW; i++) begin
            logic [31:0] d = $urandom;
            d[31] = ($urandom_range(3) != 0);
            cfg_write(1, i, d);
        end
        for (int k = 0; k < 400; k++) begin
            logic [31:0] va = $urandom;
            if ($urandom_range(7) != 0) va[31:29] = va[31] ? 3'b111 : 3'b000;
            translate(va, 1'($urandom), 1'($urandom), CTX_W'($urandom), 0, 0, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule